// File: doc/BRIEF.md
# Programmable-Shift Fixed-Point Multiplier

This block multiplies two signed fixed-point operands. It then renormalizes the double-width product by a shift amount that is given with each operation. It does not always take the upper half of the product. Because both operands are signed, the top bit of each one carries only the sign. Taking the raw high half would therefore halve the magnitude and waste a bit of precision. With a runtime shift, one datapath serves Q1.15 (shift 15), Q1.31 (shift 31), Q7.24 (shift 24), Q15.16 (shift 16) and any other binary-point position the caller picks.

A format select chooses narrow (16-bit) or wide (32-bit) operands. In narrow mode only the low half of each operand input is used, and the result is returned sign-extended to the full output width. The shift is arithmetic and truncates toward negative infinity. An optional round input adds half an LSB at the shift position before truncation. A result that does not fit the selected width saturates and raises an overflow flag. The result, the flag and the output strobe are registered, so they appear one clock after the operation is presented.

Top module: `fxp_shift_mul`

## Requirements
- R1: With `fmt_wide`=0, the operands are bits [15:0] of `op_a`/`op_b` taken as signed values. The result is floor(a*b / 2^shamt), returned sign-extended to 32 bits. For example, 32767*32767 with shift 15 gives 32766, and with shift 16 it gives 16383.
- R2: With `fmt_wide`=1, the operands are full signed 32-bit values, the product is 64 bits, and the result is floor(a*b / 2^shamt). For example, 0x40000000*0x40000000 with shift 31 gives 0x20000000.
- R3: A shift amount greater than 2W-1 is treated as 2W-1, where W is 16 in narrow mode and 32 in wide mode.
- R4: If the renormalized value exceeds the signed W-bit range, the result becomes the most positive or most negative W-bit value (sign-extended to 32 bits) and `ovf` is 1. Otherwise `ovf` is 0. For example, -32768*-32768 with shift 15 gives 32767 with `ovf`=1.
- R5: When `rnd`=1 and the effective shift s is nonzero, 2^(s-1) is added to the product before the shift. When s is 0, `rnd` has no effect.
- R6: `out_valid` equals `in_valid` from the previous clock, and `result`/`ovf` in that cycle belong to the operation presented then.
- R7: A synchronous active-high `rst` clears `out_valid`, `ovf` and `result` on the next clock.
- R8: In narrow mode, bits [31:16] of `op_a` and `op_b` have no effect on the result.
- R9: `ovf` is 0 in every cycle where `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| fmt_wide | input | 1 | 0: 16-bit operands, 1: 32-bit operands |
| rnd | input | 1 | Round half-up at the shift position |
| shamt | input | 6 | Renormalization right-shift amount |
| op_a | input | 32 | Signed multiplicand |
| op_b | input | 32 | Signed multiplier |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| result | output | 32 | Saturated, renormalized product |
| ovf | output | 1 | Saturation occurred on this result |

## Verification
Rounding and saturation can act on the same operation: the rounding increment can carry a value that truncation would leave in range across the saturation limit. The bench provokes this with narrow operands 255*257 = 65535 at shift 1. Without rounding the result is 32767 with no overflow. With rounding it must saturate to 32767 and raise `ovf`. Rounding also meets shift clamping: -32768*-32768 at requested shift 40 with rounding must give 1, as at shift 31. An unclamped shift would give 0. Each case is judged against a wide-integer model in the bench.

// File: rtl/fxp_shift_mul.sv
module fxp_shift_mul #(
  parameter int W = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic                       fmt_wide,
  input  logic                       rnd,
  input  logic [$clog2(2*W)-1:0]     shamt,
  input  logic [W-1:0]               op_a,
  input  logic [W-1:0]               op_b,
  output logic                       out_valid,
  output logic [W-1:0]               result,
  output logic                       ovf
);
  localparam int HW   = W / 2;
  localparam int SH_W = $clog2(2*W);
  localparam int EW   = 2*W + 2;
  localparam logic [SH_W-1:0] SH_MAX_N = SH_W'(2*HW - 1);
  localparam logic [SH_W-1:0] SH_MAX_W = SH_W'(2*W - 1);
  localparam logic signed [EW-1:0] HI_W = (EW'(1) <<< (W-1)) - EW'(1);
  localparam logic signed [EW-1:0] HI_N = (EW'(1) <<< (HW-1)) - EW'(1);

  logic signed [W-1:0]   a_s, b_s;
  logic signed [2*W-1:0] prod;
  logic [SH_W-1:0]       sh_lim, sh_eff;
  logic signed [EW-1:0]  rnd_add, shifted, hi, lo;
  logic                  pos_ovf, neg_ovf;
  logic [W-1:0]          sat_val;

  assign a_s    = fmt_wide ? op_a : {{HW{op_a[HW-1]}}, op_a[HW-1:0]};
  assign b_s    = fmt_wide ? op_b : {{HW{op_b[HW-1]}}, op_b[HW-1:0]};
  assign prod   = a_s * b_s;
  assign sh_lim = fmt_wide ? SH_MAX_W : SH_MAX_N;
  assign sh_eff = (shamt > sh_lim) ? sh_lim : shamt;

  always_comb begin
    rnd_add = '0;
    if (rnd && sh_eff != '0)
      rnd_add = EW'(1) <<< (sh_eff - SH_W'(1));
  end

  assign shifted = (EW'(prod) + rnd_add) >>> sh_eff;
  assign hi      = fmt_wide ? HI_W : HI_N;
  assign lo      = -hi - EW'(1);
  assign pos_ovf = shifted > hi;
  assign neg_ovf = shifted < lo;
  assign sat_val = pos_ovf ? hi[W-1:0] : (neg_ovf ? lo[W-1:0] : shifted[W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ovf       <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      ovf       <= in_valid & (pos_ovf | neg_ovf);
      if (in_valid) result <= sat_val;
    end
  end

  logic nar_q;
  always_ff @(posedge clk) nar_q <= ~fmt_wide;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R6
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R6
  AST_OVF_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) ovf |-> out_valid); // R9
  AST_SAT_EXTREME: assert property (@(posedge clk) disable iff (rst)
    ovf |-> (result == W'(HI_N) || result == W'(-HI_N - EW'(1)) ||
             result == W'(HI_W) || result == W'(-HI_W - EW'(1)))); // R4
  AST_NARROW_SEXT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && nar_q) |-> (result[W-1:HW] == {HW{result[HW-1]}})); // R1
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && !ovf)); // R7
endmodule

// File: tb/fxp_shift_mul_bench.sv
module fxp_shift_mul_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, fmt_wide = 1'b0, rnd = 1'b0;
  logic [5:0]  shamt = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid, ovf;
  logic [31:0] result;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  fxp_shift_mul #(.W(32)) u_fxp_shift_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_wide(fmt_wide), .rnd(rnd),
    .shamt(shamt), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .ovf(ovf));

  function automatic logic [32:0] model(bit wide, bit rd, int sh, logic [31:0] a, logic [31:0] b);
    logic signed [71:0] pa, pb, p, hi, lo;
    int w = wide ? 32 : 16;
    if (sh > 2*w - 1) sh = 2*w - 1;
    pa = wide ? {{40{a[31]}}, a} : {{56{a[15]}}, a[15:0]};
    pb = wide ? {{40{b[31]}}, b} : {{56{b[15]}}, b[15:0]};
    p  = pa * pb;
    if (rd && sh != 0) p = p + (72'sd1 <<< (sh - 1));
    p  = p >>> sh;
    hi = (72'sd1 <<< (w - 1)) - 72'sd1;
    lo = -hi - 72'sd1;
    if (p > hi) return {1'b1, hi[31:0]};
    if (p < lo) return {1'b1, lo[31:0]};
    return {1'b0, p[31:0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(string req, bit wide, bit rd, int sh, logic [31:0] a, logic [31:0] b);
    logic [32:0] e;
    @(negedge clk);
    in_valid = 1'b1; fmt_wide = wide; rnd = rd; shamt = 6'(sh); op_a = a; op_b = b;
    e = model(wide, rd, sh, a, b);
    @(negedge clk);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, result, e[31:0]);
    check({req, " ovf"}, {31'd0, ovf}, {31'd0, e[32]});
  endtask

  task automatic exact(string req, bit wide, bit rd, int sh, logic [31:0] a, logic [31:0] b,
                       logic [31:0] exp_r, bit exp_o);
    @(negedge clk);
    in_valid = 1'b1; fmt_wide = wide; rnd = rd; shamt = 6'(sh); op_a = a; op_b = b;
    @(negedge clk);
    check({req, " result"}, result, exp_r);
    check({req, " ovf"}, {31'd0, ovf}, {31'd0, exp_o});
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (2) @(negedge clk);
    check("R7 reset valid", {31'd0, out_valid}, 32'd0);
    check("R7 reset ovf", {31'd0, ovf}, 32'd0);
    check("R7 reset result", result, 32'd0);
    rst = 1'b0;

    exact("R1 q15", 0, 0, 15, 32'd32767, 32'd32767, 32'd32766, 0);
    exact("R1 high-half", 0, 0, 16, 32'd32767, 32'd32767, 32'd16383, 0);
    exact("R1 negative", 0, 0, 15, 32'hFFFF8000, 32'd32767, 32'hFFFF8001, 0);
    exact("R2 half*half", 1, 0, 31, 32'h40000000, 32'h40000000, 32'h20000000, 0);
    exact("R2 min*max", 1, 0, 31, 32'h80000000, 32'h7FFFFFFF, 32'h80000001, 0);
    exact("R2 m1*m1", 1, 0, 31, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'd0, 0);
    exact("R3 clamp round", 0, 1, 40, 32'h8000, 32'h8000, 32'd1, 0);
    exact("R3 clamp 63", 0, 0, 63, 32'h8000, 32'h7FFF, 32'hFFFFFFFF, 0);
    exact("R4 min*min q15", 0, 0, 15, 32'h8000, 32'h8000, 32'd32767, 1);
    exact("R4 neg sat", 0, 0, 0, 32'd32767, 32'h8000, 32'hFFFF8000, 1);
    exact("R4 wide min*min", 1, 0, 31, 32'h80000000, 32'h80000000, 32'h7FFFFFFF, 1);
    exact("R4 R5 carry no rnd", 0, 0, 1, 32'd255, 32'd257, 32'd32767, 0);
    exact("R4 R5 carry rnd", 0, 1, 1, 32'd255, 32'd257, 32'd32767, 1);
    exact("R5 rnd up", 0, 1, 1, 32'd3, 32'd1, 32'd2, 0);
    exact("R5 floor", 0, 0, 1, 32'hFFFFFFFD, 32'd1, 32'hFFFFFFFE, 0);
    exact("R5 rnd neg", 0, 1, 1, 32'hFFFFFFFD, 32'd1, 32'hFFFFFFFF, 0);
    exact("R5 sh0 rnd", 0, 1, 0, 32'd5, 32'd1, 32'd5, 0);
    exact("R8 upper ignored", 0, 0, 15, 32'hABCD7FFF, 32'h12347FFF, 32'd32766, 0);
    exact("R1 zero", 0, 1, 7, 32'd0, 32'hFFFF, 32'd0, 0);

    @(negedge clk);
    in_valid = 1'b0; op_a = 32'h8000; op_b = 32'h8000; fmt_wide = 0; shamt = 6'd0;
    @(negedge clk);
    check("R6 idle valid", {31'd0, out_valid}, 32'd0);
    check("R9 idle ovf", {31'd0, ovf}, 32'd0);

    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 64; s++)
        for (int k = 0; k < 6; k++) begin
          logic [31:0] a, b;
          a = $urandom(); b = $urandom();
          if (k == 0) begin a = 32'hFFFFFFFF; b = (f == 1) ? 32'h80000000 : 32'h8000; end
          if (k == 1) begin a = (f == 1) ? 32'h7FFFFFFF : 32'h7FFF; b = a; end
          op(f == 1 ? "R2 R3 R4 R5 rand" : "R1 R3 R4 R5 R8 rand", f[0], 1'($urandom()), s, a, b);
        end

    @(negedge clk);
    in_valid = 1'b1; fmt_wide = 0; rnd = 0; shamt = 6'd0; op_a = 32'h7FFF; op_b = 32'h7FFF; rst = 1'b1;
    @(negedge clk);
    check("R7 mid reset valid", {31'd0, out_valid}, 32'd0);
    check("R7 mid reset ovf", {31'd0, ovf}, 32'd0);
    rst = 1'b0; in_valid = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule